// File: doc/BRIEF.md
# Indirect-Window Interrupt Routing Register File

This block is the software-visible register file of a 24-input interrupt router. Software does not reach each register at its own address. It writes an index into a select register and then reads or writes the chosen register through a single data window. The bus is a simple 32-bit interface with one strobe per direction. Only the low byte of the byte offset is decoded.

The indexed space holds four kinds of register:
- an identification byte;
- a fixed version word;
- an arbitration word that always reads zero;
- one 64-bit redirection entry per input, reached as a low half and a high half.

Writes to an entry are screened field by field. A low-half write that carries an unusable vector is dropped. Two status bits keep their old values. Only the destination byte of a high half can be stored.

All entries are exported side by side to a separate dispatch block. A one-cycle pulse tells the dispatch block that some entry was just rewritten. Read data is registered, so it returns one cycle after the read strobe.

Top module: `irq_route_regs`

## Requirements
- R1: Only `bus_addr` values 0x00 (select register) and 0x10 (data window) are decoded. A read at any other offset returns 0xFFFFFFFF, and a write there changes no state.
- R2: A write at offset 0x00 stores `bus_wdata[7:0]` into the select register. Reading offset 0x00 returns that byte zero-extended to 32 bits.
- R3: The identification byte sits at select 0x00. A window write stores `bus_wdata[31:24]`, and a window read returns the byte in bits 31:24 with zeros below. After reset the byte equals `cfg_id`.
- R4: Select 0x01 reads 0x00170011: the highest entry index (23) in bits 23:16 and version 0x11 in bits 7:0. Select 0x02 reads 0. Window writes to either select change nothing.
- R5: Any select value other than 0x00, 0x01, 0x02 and 0x10..0x3F reads 0xFFFFFFFF through the window, and window writes to it change nothing.
- R6: Entry n has its low half at select 0x10+2n and its high half at 0x11+2n. A low-half write is accepted only when `bus_wdata[16]` (mask) is 1, or when `bus_wdata[7:0]` lies in 0x10..0xFE inclusive. Otherwise the entry keeps its value.
- R7: An accepted low-half write stores every written bit of 31:0 except bits 12 and 14, which keep their previous values. Reserved delivery-mode codes in bits 10:8 are stored as written.
- R8: A high-half write stores `bus_wdata[31:24]` into entry bits 63:56. Entry bits 55:32 are always zero, and a high-half read returns bits 63:32.
- R9: Reset clears the select register, loads the identification byte from `cfg_id`, and sets every entry to 0x0000000000010000 (masked).
- R10: `entry_written` is high for exactly the one cycle after an accepted entry write (either half). It stays low after rejected or non-entry writes.
- R11: `bus_rdata` is updated on the clock edge that samples `bus_rd` and holds its value while `bus_rd` is low. Entry `n` appears on `entries_flat[64n+63:64n]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_id | input | 8 | Identification byte loaded at reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| entries_flat | output | 1536 | All redirection entries, entry n at bits 64n+63:64n |
| entry_written | output | 1 | One-cycle pulse after an accepted entry write |

## Verification
The checker watches the following on every cycle:
- the pulse timing against the internal accept event;
- that the status bits 12 and 14 and upper bits 55:32 of every entry stay zero;
- that `bus_rdata` holds its value without a read strobe;
- that a bad offset reads all ones and the select register reads back zero-extended;
- that a low-half write with an out-of-range vector and clear mask leaves all entries untouched.

Some behaviour can only be shown by the bench's scenarios, where a behavioural model tracks every register:
- the exact values stored for reserved delivery modes and for boundary vectors 0x0F, 0x10, 0xFE and 0xFF;
- the version and identification words;
- that writes to read-only and unassigned selects are ignored;
- the reset values after a mid-run reset.

// File: rtl/irq_route_pkg.sv
package irq_route_pkg;
  localparam int WORD_W = 32;
  localparam int ENT_W  = 64;
  localparam logic [ENT_W-1:0]  ENTRY_RESET = 64'h0000_0000_0001_0000;
  // Low-half bits that software cannot write (delivery status, remote IRR)
  localparam logic [WORD_W-1:0] LO_KEEP     = 32'h0000_5000;

  // A low-half write is usable if masked or if its vector is in range
  function automatic logic lo_accept(input logic [WORD_W-1:0] w);
    return w[16] || ((w[7:0] >= 8'h10) && (w[7:0] <= 8'hFE));
  endfunction

  function automatic logic [WORD_W-1:0] merge_lo(input logic [WORD_W-1:0] old_w,
                                                  input logic [WORD_W-1:0] w);
    return (w & ~LO_KEEP) | (old_w & LO_KEEP);
  endfunction

  function automatic logic [WORD_W-1:0] hi_word(input logic [WORD_W-1:0] w);
    return {w[31:24], 24'h0};
  endfunction

  function automatic logic [WORD_W-1:0] version_word(input int num, input logic [7:0] ver);
    logic [7:0] max_idx;
    max_idx = 8'(num - 1);
    return {8'h00, max_idx, 8'h00, ver};
  endfunction
endpackage

// File: rtl/irq_route_entry.sv
module irq_route_entry
  import irq_route_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [WORD_W-1:0] wdata,
  output logic              accepted,
  output logic [ENT_W-1:0]  entry
);
  logic take_lo;

  assign take_lo  = wr_lo && lo_accept(wdata);
  assign accepted = take_lo || wr_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      entry <= ENTRY_RESET;
    end else if (take_lo) begin
      entry[31:0] <= merge_lo(entry[31:0], wdata);
    end else if (wr_hi) begin
      entry[63:32] <= hi_word(wdata);
    end
  end
endmodule

// File: rtl/irq_route_rdmux.sv
module irq_route_rdmux
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [7:0]  SEL_OFFSET  = 8'h00,
  parameter logic [7:0]  WIN_OFFSET  = 8'h10,
  parameter logic [7:0]  ENTRY_BASE  = 8'h10,
  parameter logic [7:0]  VERSION     = 8'h11
) (
  input  logic [7:0]                   addr,
  input  logic [7:0]                   sel,
  input  logic [7:0]                   id,
  input  logic [NUM_ENTRIES*ENT_W-1:0] entries,
  output logic [WORD_W-1:0]            word
);
  localparam int SEL_LIMIT = int'(ENTRY_BASE) + 2 * NUM_ENTRIES;
  localparam logic [WORD_W-1:0] VER_WORD = version_word(NUM_ENTRIES, VERSION);

  logic [WORD_W-1:0] win_word;
  logic [7:0]        rel;
  logic [ENT_W-1:0]  picked;

  assign rel = sel - ENTRY_BASE;

  always_comb begin
    picked = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (int'(rel[7:1]) == k) picked = entries[k*ENT_W +: ENT_W];
    end
  end

  always_comb begin
    if (sel == 8'h00)      win_word = {id, 24'h0};
    else if (sel == 8'h01) win_word = VER_WORD;
    else if (sel == 8'h02) win_word = '0;
    else if (sel >= ENTRY_BASE && int'(sel) < SEL_LIMIT)
      win_word = rel[0] ? picked[63:32] : picked[31:0];
    else                   win_word = '1;
  end

  always_comb begin
    if (addr == SEL_OFFSET)      word = {24'h0, sel};
    else if (addr == WIN_OFFSET) word = win_word;
    else                         word = '1;
  end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [7:0]  SEL_OFFSET  = 8'h00,
  parameter logic [7:0]  WIN_OFFSET  = 8'h10,
  parameter logic [7:0]  ENTRY_BASE  = 8'h10,
  parameter logic [7:0]  VERSION     = 8'h11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [7:0]                   cfg_id,
  input  logic [7:0]                   bus_addr,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [WORD_W-1:0]            bus_wdata,
  output logic [WORD_W-1:0]            bus_rdata,
  output logic [NUM_ENTRIES*ENT_W-1:0] entries_flat,
  output logic                         entry_written
);
  logic [7:0]             sel_q;
  logic [7:0]             id_q;
  logic                   sel_wr;
  logic                   win_wr;
  logic [NUM_ENTRIES-1:0] ent_acc;
  logic                   ent_wr_any;
  logic [WORD_W-1:0]      rd_word;

  assign sel_wr     = bus_wr && (bus_addr == SEL_OFFSET);
  assign win_wr     = bus_wr && (bus_addr == WIN_OFFSET);
  assign ent_wr_any = |ent_acc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 8'h00;
      id_q  <= cfg_id;
    end else begin
      if (sel_wr) sel_q <= bus_wdata[7:0];
      if (win_wr && sel_q == 8'h00) id_q <= bus_wdata[31:24];
    end
  end

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    localparam logic [7:0] LO_SEL = 8'(int'(ENTRY_BASE) + 2 * i);
    localparam logic [7:0] HI_SEL = 8'(int'(ENTRY_BASE) + 2 * i + 1);
    irq_route_entry u_entry (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (win_wr && sel_q == LO_SEL),
      .wr_hi    (win_wr && sel_q == HI_SEL),
      .wdata    (bus_wdata),
      .accepted (ent_acc[i]),
      .entry    (entries_flat[i*ENT_W +: ENT_W])
    );
  end

  irq_route_rdmux #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .SEL_OFFSET  (SEL_OFFSET),
    .WIN_OFFSET  (WIN_OFFSET),
    .ENTRY_BASE  (ENTRY_BASE),
    .VERSION     (VERSION)
  ) u_rdmux (
    .addr    (bus_addr),
    .sel     (sel_q),
    .id      (id_q),
    .entries (entries_flat),
    .word    (rd_word)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rdata     <= '0;
      entry_written <= 1'b0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      entry_written <= ent_wr_any;
    end
  end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk
  import irq_route_pkg::*;
#(
  parameter int          NUM_ENTRIES = 24,
  parameter logic [7:0]  SEL_OFFSET  = 8'h00,
  parameter logic [7:0]  WIN_OFFSET  = 8'h10,
  parameter logic [7:0]  ENTRY_BASE  = 8'h10
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [7:0]                   bus_addr,
  input logic                         bus_wr,
  input logic                         bus_rd,
  input logic [WORD_W-1:0]            bus_wdata,
  input logic [WORD_W-1:0]            bus_rdata,
  input logic [NUM_ENTRIES*ENT_W-1:0] entries_flat,
  input logic                         entry_written,
  input logic [7:0]                   sel_q,
  input logic                         ent_wr_any
);
  localparam int SEL_LIMIT = int'(ENTRY_BASE) + 2 * NUM_ENTRIES;

  logic [7:0] rel;
  logic       lo_sel;
  logic       bad_lo_wr;

  assign rel       = sel_q - ENTRY_BASE;
  assign lo_sel    = (sel_q >= ENTRY_BASE) && (int'(sel_q) < SEL_LIMIT) && !rel[0];
  assign bad_lo_wr = bus_wr && bus_addr == WIN_OFFSET && lo_sel && !bus_wdata[16]
                     && (bus_wdata[7:0] < 8'h10 || bus_wdata[7:0] == 8'hFF);

  // R10: pulse follows the accept event by one cycle
  a_r10_pulse_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    ent_wr_any |=> entry_written);
  a_r10_no_spurious_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_wr_any |=> !entry_written);

  // R11: read data holds without a read strobe
  a_r11_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));

  // R1: undecoded offsets read all ones
  a_r1_bad_offset_read: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr != SEL_OFFSET && bus_addr != WIN_OFFSET) |=> bus_rdata == 32'hFFFF_FFFF);

  // R2: select register reads back zero-extended
  a_r2_sel_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == SEL_OFFSET) |=> bus_rdata == {24'h0, $past(sel_q)});

  // R6: rejected low-half write leaves every entry unchanged
  a_r6_reject_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    bad_lo_wr |=> $stable(entries_flat));

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent_chk
    // R7: status bits 12 and 14 never become set
    a_r7_status_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
      entries_flat[i*ENT_W + 12] == 1'b0 && entries_flat[i*ENT_W + 14] == 1'b0);
    // R8: upper bits below the destination stay zero
    a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
      entries_flat[i*ENT_W + 32 +: 24] == 24'h0);
  end
endmodule

bind irq_route_regs irq_route_regs_chk #(
  .NUM_ENTRIES (NUM_ENTRIES),
  .SEL_OFFSET  (SEL_OFFSET),
  .WIN_OFFSET  (WIN_OFFSET),
  .ENTRY_BASE  (ENTRY_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_addr      (bus_addr),
  .bus_wr        (bus_wr),
  .bus_rd        (bus_rd),
  .bus_wdata     (bus_wdata),
  .bus_rdata     (bus_rdata),
  .entries_flat  (entries_flat),
  .entry_written (entry_written),
  .sel_q         (sel_q),
  .ent_wr_any    (ent_wr_any)
);

// File: tb/irq_route_regs_bench.sv
module irq_route_regs_bench;
  localparam int N = 24;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [7:0]    cfg_id = 8'h05;
  logic [7:0]    bus_addr = 8'h00;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [31:0]   bus_wdata = 32'h0;
  logic [31:0]   bus_rdata;
  logic [N*64-1:0] entries_flat;
  logic          entry_written;

  irq_route_regs u_irq_route_regs (
    .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .entries_flat(entries_flat), .entry_written(entry_written)
  );

  always #2 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R9";
  logic  model_on = 1'b0;

  // Behavioural reference model
  logic [63:0] m_ent [N];
  logic [7:0]  m_sel, m_id;
  logic [31:0] m_rdata;
  logic        m_pulse;

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int s;
    s = m_sel;
    if (a == 8'h00) return 32'(m_sel);
    if (a != 8'h10) return 32'hFFFF_FFFF;
    if (s == 0) return 32'(m_id) << 24;
    if (s == 1) return 32'h0017_0011;
    if (s == 2) return 32'h0;
    if (s >= 16 && s < 16 + 2 * N)
      return (s % 2 == 0) ? m_ent[(s - 16) / 2][31:0] : m_ent[(s - 16) / 2][63:32];
    return 32'hFFFF_FFFF;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = 0; m_id = cfg_id; m_rdata = 0; m_pulse = 0;
      for (int k = 0; k < N; k++) m_ent[k] = 64'h1_0000;
    end else begin
      int s; int vec; logic hit;
      hit = 0;
      s = m_sel;
      if (bus_rd) m_rdata = m_read(bus_addr);
      if (bus_wr && bus_addr == 8'h00) m_sel = bus_wdata[7:0];
      if (bus_wr && bus_addr == 8'h10) begin
        if (s == 0) m_id = bus_wdata[31:24];
        else if (s >= 16 && s < 16 + 2 * N) begin
          if (s % 2 == 1) begin
            m_ent[(s - 16) / 2][63:32] = {bus_wdata[31:24], 24'h0};
            hit = 1;
          end else begin
            vec = int'(bus_wdata[7:0]);
            if (bus_wdata[16] || (vec > 15 && vec < 255)) begin
              for (int b = 0; b < 32; b++)
                if (b != 12 && b != 14) m_ent[(s - 16) / 2][b] = bus_wdata[b];
              hit = 1;
            end
          end
        end
      end
      m_pulse = hit;
    end
  end

  task automatic check(input string req, input logic [1535:0] act, input logic [1535:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // Compare every cycle against the model
  always @(negedge clk) begin
    if (model_on && rst_n) begin
      logic [N*64-1:0] flat;
      for (int k = 0; k < N; k++) flat[k*64 +: 64] = m_ent[k];
      check(cur_req, 1536'(bus_rdata), 1536'(m_rdata), "model rdata");
      check(cur_req, 1536'(entry_written), 1536'(m_pulse), "model pulse");
      check(cur_req, flat, 1536'(entries_flat), "model entries");
    end
  end

  logic last_pulse;

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    last_pulse = entry_written;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_sel(input logic [7:0] s, output logic [31:0] d);
    wr(8'h00, 32'(s));
    rd(8'h10, d);
  endtask

  task automatic expect32(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    check(req, 1536'(act), 1536'(exp), what);
  endtask

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_on = 1'b1;
    @(negedge clk);

    // R9 reset state
    cur_req = "R9";
    rd(8'h00, d);          expect32("R9", d, 32'h0, "select after reset");
    rd_sel(8'h00, d);      expect32("R3", d, 32'h0500_0000, "id from cfg_id");
    rd_sel(8'h10, d);      expect32("R9", d, 32'h0001_0000, "entry0 low reset");
    rd_sel(8'h11, d);      expect32("R9", d, 32'h0, "entry0 high reset");

    // R2 select register width
    cur_req = "R2";
    wr(8'h00, 32'hABCD_1234);
    rd(8'h00, d);          expect32("R2", d, 32'h0000_0034, "select zero-extended");

    // R1 undecoded offsets
    cur_req = "R1";
    rd(8'h04, d);          expect32("R1", d, 32'hFFFF_FFFF, "offset 0x04 read");
    wr(8'h20, 32'h0000_0077);
    rd(8'h00, d);          expect32("R1", d, 32'h0000_0034, "select after stray write");

    // R3 identification
    cur_req = "R3";
    wr(8'h00, 32'h0);
    wr(8'h10, 32'hC3FF_FFFF);
    rd(8'h10, d);          expect32("R3", d, 32'hC300_0000, "id write/read");

    // R4 read-only words
    cur_req = "R4";
    rd_sel(8'h01, d);      expect32("R4", d, 32'h0017_0011, "version");
    wr(8'h10, 32'h1234_5678);
    rd(8'h10, d);          expect32("R4", d, 32'h0017_0011, "version after write");
    rd_sel(8'h02, d);      expect32("R4", d, 32'h0, "arbitration");
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);          expect32("R4", d, 32'h0, "arbitration after write");

    // R5 unassigned selects
    cur_req = "R5";
    rd_sel(8'h03, d);      expect32("R5", d, 32'hFFFF_FFFF, "select 0x03");
    wr(8'h10, 32'h0000_0042);
    rd_sel(8'h40, d);      expect32("R5", d, 32'hFFFF_FFFF, "select 0x40");
    wr(8'h10, 32'h0000_0042);
    rd_sel(8'h0F, d);      expect32("R5", d, 32'hFFFF_FFFF, "select 0x0F");

    // R6 vector filter on entry 3 low (select 0x16)
    cur_req = "R6";
    wr(8'h00, 32'h16);
    wr(8'h10, 32'h0000_000F);
    expect32("R10", 32'(last_pulse), 32'h0, "no pulse on rejected write");
    rd(8'h10, d);          expect32("R6", d, 32'h0001_0000, "vector 0x0F rejected");
    wr(8'h10, 32'h0000_00FF);
    rd(8'h10, d);          expect32("R6", d, 32'h0001_0000, "vector 0xFF rejected");
    wr(8'h10, 32'h0000_A010);
    expect32("R10", 32'(last_pulse), 32'h1, "pulse on accepted write");
    rd(8'h10, d);          expect32("R6", d, 32'h0000_A010, "vector 0x10 accepted");
    wr(8'h10, 32'h0001_00FF);
    rd(8'h10, d);          expect32("R6", d, 32'h0001_00FF, "masked 0xFF accepted");
    wr(8'h10, 32'h0000_00FE);
    rd(8'h10, d);          expect32("R6", d, 32'h0000_00FE, "vector 0xFE accepted");

    // R7 status bits kept, reserved mode stored (entry 5 low = 0x1A)
    cur_req = "R7";
    wr(8'h00, 32'h1A);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);          expect32("R7", d, 32'hFFFF_AFFF, "all-ones low write");
    wr(8'h10, 32'h0000_0325);
    rd(8'h10, d);          expect32("R7", d, 32'h0000_0325, "reserved delivery mode");

    // R8 high half of entry 23 (select 0x3F)
    cur_req = "R8";
    wr(8'h00, 32'h3F);
    wr(8'h10, 32'hFFFF_FFFF);
    expect32("R10", 32'(last_pulse), 32'h1, "pulse on high write");
    rd(8'h10, d);          expect32("R8", d, 32'hFF00_0000, "destination only");
    expect32("R11", entries_flat[23*64 +: 32], 32'h0001_0000, "entry23 low on export");
    expect32("R8", entries_flat[23*64+32 +: 32], 32'hFF00_0000, "entry23 high on export");

    // R11 hold without read strobe
    cur_req = "R11";
    wr(8'h00, 32'h02);
    repeat (3) @(negedge clk);
    expect32("R11", bus_rdata, 32'hFF00_0000, "rdata held");

    // R9 mid-run reset
    cur_req = "R9";
    cfg_id = 8'h2A;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    rd_sel(8'h1A, d);      expect32("R9", d, 32'h0001_0000, "entry5 after reset");
    rd_sel(8'h3F, d);      expect32("R9", d, 32'h0, "entry23 high after reset");
    rd_sel(8'h00, d);      expect32("R9", d, 32'h2A00_0000, "id reloaded");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule